// File: doc/BRIEF.md
# ASCII Hex Frame Checksum Checker

This block sits behind a character receiver on a serial link that carries frames as printable text. It takes one character per strobe, waits for a colon, and then turns each pair of hexadecimal characters into a byte, high nibble first. Each decoded byte appears on the byte output for one cycle. The bytes are added into an 8-bit running total.

The last byte before the carriage-return / line-feed terminator is the frame check byte. Its correct value is the two's complement of the modulo-256 sum of all earlier bytes. The block checks it when the line feed arrives. It pulses frame done together with exactly one of the verdict flags, checksum good or checksum bad.

A character that does not fit the frame grammar raises a one-cycle error flag. The block then drops the frame and ignores input until the next colon. A colon that arrives in the middle of a frame throws away the partial frame and starts a new one.

Top module: `lrc_frame_checker`

## Requirements
- R1: After the asynchronous active-low reset, all outputs are low and the block is idle. While idle, every character other than ':' (3AH) is ignored: it causes no byte, no error and no done pulse.
- R2: Inside a frame, two hex characters form one byte, the first giving bits 7:4 and the second bits 3:0. Digits '0'-'9', 'A'-'F' and 'a'-'f' are accepted. `byte_valid_o` is high for one cycle, in the cycle after the second character is taken, with the byte on `byte_o`.
- R3: The running sum of decoded bytes is kept modulo 256, and carries out of bit 7 are dropped.
- R4: When LF (0AH) follows CR (0DH), `frame_done_o` and `lrc_ok_o` pulse together for one cycle if the final byte equals the two's complement of the 8-bit sum of all earlier bytes of the frame.
- R5: If the final byte differs from that value, `frame_done_o` and `lrc_bad_o` pulse together instead.
- R6: Inside a frame, a character that is neither a hex digit, ':', nor a legal terminator pulses `char_err_o` for one cycle and returns the block to idle. No bytes are produced until the next ':'.
- R7: A ':' arriving mid-frame discards the partial frame and its sum without raising an error, and a new frame begins.
- R8: CR after an odd number of hex characters, CR before any byte, or any character other than LF after CR pulses `char_err_o` and returns the block to idle.
- R9: `lrc_ok_o` and `lrc_bad_o` are never high together, and neither is high without `frame_done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| char_i | input | 8 | Received character |
| char_valid_i | input | 1 | Strobe: char_i is valid this cycle |
| byte_o | output | 8 | Decoded byte |
| byte_valid_o | output | 1 | One-cycle strobe for byte_o |
| frame_done_o | output | 1 | One-cycle pulse when a frame ends with LF |
| lrc_ok_o | output | 1 | Checksum matched (with frame_done_o) |
| lrc_bad_o | output | 1 | Checksum mismatched (with frame_done_o) |
| char_err_o | output | 1 | One-cycle pulse on a malformed character |

## Verification
The assertions assume the inputs are known and that `char_i` is meaningful only in cycles where `char_valid_i` is high. They also assume the strobe has been low during reset, so the one-cycle look-back after reset never sees a character. The bench drives every character for exactly one cycle, with idle cycles in between. It holds the strobe low throughout reset. It sweeps all 256 single-byte values in both letter cases, with good and corrupted check bytes, and adds multi-byte frames and each malformed-grammar case.

// File: rtl/lrc_chk_pkg.sv
package lrc_chk_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HI, ST_LO, ST_LF} fsm_e;
  localparam logic [7:0] CH_SOF = 8'h3A;
  localparam logic [7:0] CH_CR  = 8'h0D;
  localparam logic [7:0] CH_LF  = 8'h0A;
endpackage

// File: rtl/lrc_hex_decode.sv
module lrc_hex_decode #(
  parameter int CHAR_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [CHAR_W-1:0] char_i,
  output logic [NIB_W-1:0]  nib_o,
  output logic              is_hex_o,
  output logic              is_sof_o,
  output logic              is_cr_o,
  output logic              is_lf_o
);
  import lrc_chk_pkg::*;
  localparam int OFS_W = CHAR_W;

  logic [OFS_W-1:0] ofs;

  always_comb begin
    is_hex_o = 1'b0;
    ofs      = '0;
    if (char_i >= 8'h30 && char_i <= 8'h39) begin
      is_hex_o = 1'b1;
      ofs      = char_i - 8'h30;
    end else if (char_i >= 8'h41 && char_i <= 8'h46) begin
      is_hex_o = 1'b1;
      ofs      = char_i - 8'h37;
    end else if (char_i >= 8'h61 && char_i <= 8'h66) begin
      is_hex_o = 1'b1;
      ofs      = char_i - 8'h57;
    end
    nib_o    = ofs[NIB_W-1:0];
    is_sof_o = (char_i == CH_SOF);
    is_cr_o  = (char_i == CH_CR);
    is_lf_o  = (char_i == CH_LF);
  end

  always_comb begin
    if (is_hex_o) AST_NIB_RANGE: assert (ofs < 16); // R2
    AST_CLASS_EXCL: assert ($countones({is_hex_o, is_sof_o, is_cr_o, is_lf_o}) <= 1); // R2
  end
endmodule

// File: rtl/lrc_byte_pack.sv
module lrc_byte_pack #(
  parameter int NIB_W  = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_load_i,
  input  logic              lo_load_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic [BYTE_W-1:0] byte_next_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o
);
  logic [NIB_W-1:0] hi_q;

  assign byte_next_o = {hi_q, nib_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q         <= '0;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
    end else begin
      byte_valid_o <= lo_load_i;
      if (hi_load_i) hi_q <= nib_i;
      if (lo_load_i) byte_o <= byte_next_o;
    end
  end

  AST_LOAD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_load_i && lo_load_i)); // R2
  AST_BYTE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> $past(lo_load_i)); // R2
endmodule

// File: rtl/lrc_sum_acc.sv
module lrc_sum_acc #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         add_i,
  input  logic [W-1:0] byte_i,
  output logic [W-1:0] sum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sum_o <= '0;
    else if (clear_i) sum_o <= '0;
    else if (add_i)   sum_o <= sum_o + byte_i; // carry dropped
  end

  AST_SUM_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (sum_o == '0)); // R7
  AST_SUM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !add_i) |=> $stable(sum_o)); // R3
endmodule

// File: rtl/lrc_frame_checker.sv
module lrc_frame_checker #(
  parameter int CHAR_W = 8,
  parameter int NIB_W  = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              char_valid_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              frame_done_o,
  output logic              lrc_ok_o,
  output logic              lrc_bad_o,
  output logic              char_err_o
);
  import lrc_chk_pkg::*;

  fsm_e              state_q;
  logic              have_byte_q;
  logic [NIB_W-1:0]  nib;
  logic              is_hex, is_sof, is_cr, is_lf;
  logic              hi_load, lo_load, clear;
  logic [BYTE_W-1:0] byte_next, sum;

  lrc_hex_decode #(.CHAR_W(CHAR_W), .NIB_W(NIB_W)) u_dec (
    .char_i   (char_i),
    .nib_o    (nib),
    .is_hex_o (is_hex),
    .is_sof_o (is_sof),
    .is_cr_o  (is_cr),
    .is_lf_o  (is_lf)
  );

  assign clear   = char_valid_i && is_sof;
  assign hi_load = char_valid_i && !is_sof && is_hex && (state_q == ST_HI);
  assign lo_load = char_valid_i && !is_sof && is_hex && (state_q == ST_LO);

  lrc_byte_pack #(.NIB_W(NIB_W)) u_pack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hi_load_i    (hi_load),
    .lo_load_i    (lo_load),
    .nib_i        (nib),
    .byte_next_o  (byte_next),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o)
  );

  lrc_sum_acc #(.W(BYTE_W)) u_sum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .add_i   (lo_load),
    .byte_i  (byte_next),
    .sum_o   (sum)
  );

  // Sum over all bytes including the check byte is zero iff the check matches.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      have_byte_q  <= 1'b0;
      frame_done_o <= 1'b0;
      lrc_ok_o     <= 1'b0;
      lrc_bad_o    <= 1'b0;
      char_err_o   <= 1'b0;
    end else begin
      frame_done_o <= 1'b0;
      lrc_ok_o     <= 1'b0;
      lrc_bad_o    <= 1'b0;
      char_err_o   <= 1'b0;
      if (char_valid_i) begin
        if (is_sof) begin
          state_q     <= ST_HI;
          have_byte_q <= 1'b0;
        end else begin
          unique case (state_q)
            ST_IDLE: ;
            ST_HI: begin
              if (is_hex) state_q <= ST_LO;
              else if (is_cr && have_byte_q) state_q <= ST_LF;
              else begin
                char_err_o <= 1'b1;
                state_q    <= ST_IDLE;
              end
            end
            ST_LO: begin
              if (is_hex) begin
                state_q     <= ST_HI;
                have_byte_q <= 1'b1;
              end else begin
                char_err_o <= 1'b1;
                state_q    <= ST_IDLE;
              end
            end
            ST_LF: begin
              state_q <= ST_IDLE;
              if (is_lf) begin
                frame_done_o <= 1'b1;
                lrc_ok_o     <= (sum == '0);
                lrc_bad_o    <= (sum != '0);
              end else begin
                char_err_o <= 1'b1;
              end
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  AST_VERDICT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> ($countones({lrc_ok_o, lrc_bad_o}) == 1)); // R9
  AST_VERDICT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrc_ok_o || lrc_bad_o) |-> frame_done_o); // R9
  AST_DONE_ON_LF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> $past(char_valid_i && char_i == CH_LF)); // R4
  AST_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_err_o |-> (state_q == ST_IDLE)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && state_q == ST_IDLE && char_i != CH_SOF)
      |=> (!char_err_o && !byte_valid_o && !frame_done_o)); // R1
  AST_SOF_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && char_i == CH_SOF) |=> (!char_err_o && state_q == ST_HI)); // R7
  AST_NO_DONE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_done_o && char_err_o)); // R8
endmodule

// File: tb/tb_lrc_frame_checker.sv
module tb_lrc_frame_checker;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] K_SOF = 8'h3A, K_CR = 8'h0D, K_LF = 8'h0A;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] char_i = '0;
  logic       char_valid_i = 1'b0;
  logic [7:0] byte_o;
  logic       byte_valid_o, frame_done_o, lrc_ok_o, lrc_bad_o, char_err_o;

  int errors = 0;
  int checks = 0;
  logic [7:0] fb [0:15];
  logic       o_bv, o_done, o_ok, o_bad, o_err;
  logic [7:0] o_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  lrc_frame_checker dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .char_i       (char_i),
    .char_valid_i (char_valid_i),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .frame_done_o (frame_done_o),
    .lrc_ok_o     (lrc_ok_o),
    .lrc_bad_o    (lrc_bad_o),
    .char_err_o   (char_err_o)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hexc(input logic [3:0] n, input bit lower);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    return (lower ? 8'h61 : 8'h41) + {4'h0, n} - 8'd10;
  endfunction

  // One character per call; outputs for that character captured afterwards.
  task automatic send_char(input logic [7:0] c);
    @(negedge clk);
    char_i = c;
    char_valid_i = 1'b1;
    @(negedge clk);
    char_valid_i = 1'b0;
    o_bv = byte_valid_o; o_b = byte_o; o_done = frame_done_o;
    o_ok = lrc_ok_o; o_bad = lrc_bad_o; o_err = char_err_o;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit lower, input string req);
    send_char(hexc(b[7:4], lower));
    check(!o_bv && !o_err, req, {o_bv, o_err}, 0);
    send_char(hexc(b[3:0], lower));
    check(o_bv && o_b == b, req, {o_bv, o_b}, {1'b1, b});
  endtask

  task automatic send_frame(input int n, input logic [7:0] delta, input bit lower, input string req);
    logic [7:0] s = '0;
    logic [7:0] chk;
    for (int i = 0; i < n; i++) s = s + fb[i];
    chk = (~s + 8'd1) + delta;
    send_char(K_SOF);
    check(!o_err && !o_done, "R7", o_err, 0);
    for (int i = 0; i < n; i++) send_byte(fb[i], lower ^ i[0], "R2");
    send_byte(chk, lower, "R3");
    send_char(K_CR);
    check(!o_done && !o_err, "R8", {o_done, o_err}, 0);
    send_char(K_LF);
    if (delta == 0)
      check(o_done && o_ok && !o_bad && !o_err, req, {o_done, o_ok, o_bad}, 3'b110);
    else
      check(o_done && !o_ok && o_bad && !o_err, req, {o_done, o_ok, o_bad}, 3'b101);
  endtask

  task automatic expect_err(input string req);
    check(o_err && !o_done && !o_bv, req, {o_err, o_done, o_bv}, 3'b100);
  endtask

  task automatic expect_quiet(input string req);
    check(!o_err && !o_done && !o_bv, req, {o_err, o_done, o_bv}, 3'b000);
  endtask

  initial begin
    repeat (200000 - 100) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lcg = 16'hACE1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!byte_valid_o && !frame_done_o && !lrc_ok_o && !lrc_bad_o && !char_err_o,
          "R1", {byte_valid_o, frame_done_o, lrc_ok_o, lrc_bad_o, char_err_o}, 0);
    rst_ni = 1'b1;
    // R1 idle ignores non-colon characters
    send_char("0"); expect_quiet("R1");
    send_char("1"); expect_quiet("R1");
    send_char(K_CR); expect_quiet("R1");
    send_char(K_LF); expect_quiet("R1");
    send_char("Z"); expect_quiet("R1");

    // R4 worked example, check byte F6
    fb[0] = 8'h01; fb[1] = 8'h03; fb[2] = 8'h04;
    fb[3] = 8'h01; fb[4] = 8'h00; fb[5] = 8'h01;
    send_frame(6, 8'h00, 1'b0, "R4");
    check(o_ok, "R4", o_ok, 1);

    // R2 R4 R5 sweep all single-byte payloads
    for (int b = 0; b < 256; b++) begin
      fb[0] = 8'(b);
      send_frame(1, 8'h00, b[0], "R4");
      send_frame(1, 8'(1 + (b % 7) * 37), b[1], "R5");
    end

    // R3 multi-byte frames, sums wrap past 8 bits
    for (int f = 0; f < 60; f++) begin
      int n = 1 + (f % 12);
      for (int i = 0; i < n; i++) begin
        lcg = {lcg[14:0], lcg[15] ^ lcg[13] ^ lcg[12] ^ lcg[10]};
        fb[i] = lcg[7:0] | 8'h80;
      end
      send_frame(n, (f % 3 == 0) ? 8'h10 : 8'h00, f[0], (f % 3 == 0) ? "R5" : "R3");
    end

    // R6 bad character, then ignored until colon
    send_char(K_SOF); send_char("0"); send_char("1");
    send_char("G"); expect_err("R6");
    send_char("0"); expect_quiet("R6");
    send_char("1"); expect_quiet("R6");
    send_char(K_CR); expect_quiet("R6");
    send_char(K_LF); expect_quiet("R6");
    fb[0] = 8'h5A; send_frame(1, 8'h00, 1'b0, "R6");

    // R7 colon mid-frame discards partial sum
    send_char(K_SOF); send_char("1"); send_char("2"); send_char("3");
    send_char(K_SOF); expect_quiet("R7");
    send_byte(8'h05, 1'b0, "R7");
    send_byte(8'hFB, 1'b1, "R7");
    send_char(K_CR); send_char(K_LF);
    check(o_done && o_ok && !o_bad, "R7", {o_done, o_ok, o_bad}, 3'b110);

    // R8 malformed terminators
    send_char(K_SOF); send_char("1"); send_char(K_CR); expect_err("R8");
    send_char(K_SOF); send_char(K_CR); expect_err("R8");
    send_char(K_SOF); send_byte(8'h01, 1'b0, "R8"); send_byte(8'hFF, 1'b0, "R8");
    send_char(K_CR); send_char("A"); expect_err("R8");
    send_char(K_LF); expect_quiet("R8");
    send_char(K_SOF); send_char(K_LF); expect_err("R8");
    fb[0] = 8'hC3; fb[1] = 8'h7D; send_frame(2, 8'h00, 1'b1, "R9");
    check(!(o_ok && o_bad), "R9", {o_ok, o_bad}, 2'b10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule